// File: doc/BRIEF.md
# Multi-Stage Capture Trigger

This block decides when a logic analyzer starts recording. It watches a bus of sampled channels and a sample-valid strobe. It walks through a short chain of condition stages, and it raises a run output once the whole chain has been satisfied in time order. Each stage compares either the current sample across all channels (parallel mode) or the last samples seen on one chosen channel (serial mode). The comparison covers only the bit positions selected by that stage's mask.

Software fills in the stage settings while the trigger is disarmed, then pulses arm. From that point the trigger evaluates one stage per valid sample, and the stage index only moves forward. Stages that are switched off are skipped. Once run is raised it stays high until the trigger is armed again or reset, so the capture logic can start on its rising edge.

Top module: `la_trigger`

## Requirements
- R1: In parallel mode a stage matches a valid sample when, for every channel whose mask bit is 1, the sample bit equals the value bit.
- R2: Channels whose mask bit is 0 do not affect a match, in either mode.
- R3: In serial mode a stage keeps a history of the chosen channel with the newest bit in bit 0. The history including the current valid sample is compared with value under mask.
- R4: The pending stage advances by one stage per matching valid sample. A later stage is never judged on the same sample that satisfied the stage before it, and stage_o never decreases except when armed.
- R5: Disabled stages are skipped. run_o rises in the cycle after the valid sample on which the highest-numbered enabled stage matches, with all earlier enabled stages already satisfied.
- R6: With no stage enabled, run_o rises after the first valid sample that follows arming.
- R7: Cycles with smp_valid_i low neither shift the serial history nor change stage_o or run_o.
- R8: Once high, run_o stays high until arm_i or reset.
- R9: Configuration writes take effect only while disarmed and are ignored while armed. Field 0 is the mask, field 1 is the value, and field 2 is the control word: bit 0 enable, bit 1 serial mode, bits [2 +: log2(channels)] serial channel.
- R10: arm_i clears stage_o, run_o and every serial history, and sets armed_o.
- R11: After reset the trigger is disarmed, run_o and stage_o are 0, and every stage is disabled.
- R12: arm_i takes priority over disarm_i. disarm_i clears armed_o and leaves run_o unchanged. No evaluation happens while the trigger is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse; clears progress and history |
| disarm_i | input | 1 | Disarm pulse; unlocks configuration |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | NUM_CH | Sampled channel bus |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_stage_i | input | STG_W | Stage addressed by the write |
| cfg_field_i | input | 2 | Field: 0 mask, 1 value, 2 control |
| cfg_data_i | input | NUM_CH | Write data |
| armed_o | output | 1 | Trigger is armed |
| run_o | output | 1 | Capture start, held |
| stage_o | output | STG_W | Index of the pending stage |

## Verification
The bench uses the defaults: 32 channels and 4 stages. This gives a full 32-bit serial history and enough stages to leave gaps of disabled stages between enabled ones, so skipping and "last enabled stage" detection both get exercised. Sparse random masks make matches frequent, which drives multi-stage chains to completion. Directed cases cover the serial bit order, history clearing on re-arm, and writes attempted while armed.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;
  typedef enum logic {
    MATCH_PARALLEL = 1'b0,
    MATCH_SERIAL   = 1'b1
  } match_mode_e;

  typedef enum logic [1:0] {
    FLD_MASK  = 2'd0,
    FLD_VALUE = 2'd1,
    FLD_CTRL  = 2'd2
  } cfg_field_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_CH_LSB   = 2;
endpackage

// File: rtl/la_trig_cfg_dec.sv
module la_trig_cfg_dec #(
  parameter int NUM_STAGES = 4,
  parameter int STG_W      = 2
) (
  input  logic                  cfg_we_i,
  input  logic [STG_W-1:0]      cfg_stage_i,
  input  logic                  armed_i,
  output logic [NUM_STAGES-1:0] stage_wr_o
);
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_dec
    assign stage_wr_o[g] = cfg_we_i && !armed_i && (int'(cfg_stage_i) == g);
  end
endmodule

// File: rtl/la_trig_stage.sv
module la_trig_stage
  import la_trig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        field_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic [NUM_CH-1:0] sample_i,
  output logic              enabled_o,
  output logic              match_o
);
  logic [NUM_CH-1:0] mask_q, val_q, hist_q, hist_next;
  logic              en_q;
  match_mode_e       mode_q;
  logic [CH_W-1:0]   ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      val_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= MATCH_PARALLEL;
      ch_q   <= '0;
    end else if (wr_i) begin
      case (field_i)
        FLD_MASK:  mask_q <= wdata_i;
        FLD_VALUE: val_q  <= wdata_i;
        FLD_CTRL: begin
          en_q   <= wdata_i[CTRL_EN_BIT];
          mode_q <= match_mode_e'(wdata_i[CTRL_MODE_BIT]);
          ch_q   <= wdata_i[CTRL_CH_LSB +: CH_W];
        end
        default: ;
      endcase
    end
  end

  // newest sample enters at bit 0
  assign hist_next = {hist_q[NUM_CH-2:0], sample_i[ch_q]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (clear_i) hist_q <= '0;
    else if (shift_i) hist_q <= hist_next;
  end

  always_comb begin
    if (mode_q == MATCH_SERIAL) match_o = ((hist_next ^ val_q) & mask_q) == '0;
    else                        match_o = ((sample_i  ^ val_q) & mask_q) == '0;
  end

  assign enabled_o = en_q;
endmodule

// File: rtl/la_trig_seq.sv
module la_trig_seq #(
  parameter int NUM_STAGES = 4,
  parameter int STG_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  arm_i,
  input  logic                  disarm_i,
  input  logic                  valid_i,
  input  logic [NUM_STAGES-1:0] en_i,
  input  logic [NUM_STAGES-1:0] match_i,
  output logic                  armed_o,
  output logic                  run_o,
  output logic [STG_W-1:0]      stage_o,
  output logic                  shift_o
);
  logic             armed_q, run_q;
  logic [STG_W-1:0] cur_q;
  logic             pend_found, later_any, step;
  int               pend_idx;

  // lowest enabled stage at or above the current index
  always_comb begin
    pend_found = 1'b0;
    pend_idx   = 0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (!pend_found && en_i[s] && s >= int'(cur_q)) begin
        pend_found = 1'b1;
        pend_idx   = s;
      end
    end
    later_any = 1'b0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (pend_found && en_i[s] && s > pend_idx) later_any = 1'b1;
    end
  end

  assign step    = armed_q && valid_i && !run_q;
  assign shift_o = armed_q && valid_i && !arm_i && !disarm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      cur_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      run_q   <= 1'b0;
      cur_q   <= '0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
    end else if (step) begin
      if (!pend_found) begin
        run_q <= 1'b1;
      end else if (match_i[pend_idx]) begin
        if (later_any) cur_q <= STG_W'(pend_idx + 1);
        else           run_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign run_o   = run_q;
  assign stage_o = cur_q;
endmodule

// File: rtl/la_trigger.sv
module la_trigger #(
  parameter int NUM_CH     = 32,
  parameter int NUM_STAGES = 4,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              smp_valid_i,
  input  logic [NUM_CH-1:0] smp_data_i,
  input  logic              cfg_we_i,
  input  logic [STG_W-1:0]  cfg_stage_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [NUM_CH-1:0] cfg_data_i,
  output logic              armed_o,
  output logic              run_o,
  output logic [STG_W-1:0]  stage_o
);
  logic [NUM_STAGES-1:0] stage_wr, stage_en, stage_match;
  logic                  hist_shift;

  la_trig_cfg_dec #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W)) u_dec (
    .cfg_we_i    (cfg_we_i),
    .cfg_stage_i (cfg_stage_i),
    .armed_i     (armed_o),
    .stage_wr_o  (stage_wr)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    la_trig_stage #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (stage_wr[g]),
      .field_i   (cfg_field_i),
      .wdata_i   (cfg_data_i),
      .clear_i   (arm_i),
      .shift_i   (hist_shift),
      .sample_i  (smp_data_i),
      .enabled_o (stage_en[g]),
      .match_o   (stage_match[g])
    );
  end

  la_trig_seq #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .disarm_i (disarm_i),
    .valid_i  (smp_valid_i),
    .en_i     (stage_en),
    .match_i  (stage_match),
    .armed_o  (armed_o),
    .run_o    (run_o),
    .stage_o  (stage_o),
    .shift_o  (hist_shift)
  );
endmodule

// File: rtl/la_trigger_chk.sv
module la_trigger_chk #(
  parameter int NUM_STAGES = 4,
  localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             disarm_i,
  input logic             smp_valid_i,
  input logic             armed_o,
  input logic             run_o,
  input logic [STG_W-1:0] stage_o
);
  p_arm_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_o && !run_o && stage_o == '0));

  p_run_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !arm_i) |=> run_o);

  p_idle_no_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !arm_i) |=> ($stable(stage_o) && $stable(run_o)));

  p_stage_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (stage_o >= $past(stage_o)));

  p_run_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(armed_o) && $past(smp_valid_i)));

  p_disarm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i && !arm_i) |=> (!armed_o && $stable(run_o)));
endmodule

bind la_trigger la_trigger_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .disarm_i    (disarm_i),
  .smp_valid_i (smp_valid_i),
  .armed_o     (armed_o),
  .run_o       (run_o),
  .stage_o     (stage_o)
);

// File: tb/tb_la_trigger.sv
module tb_la_trigger;
  localparam int NCH = 32;
  localparam int NST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 0, disarm = 0, valid = 0, we = 0;
  logic [NCH-1:0] data = '0, wdata = '0;
  logic [1:0] stg = '0, fld = '0;
  logic armed, run;
  logic [1:0] stage;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  la_trigger #(.NUM_CH(NCH), .NUM_STAGES(NST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .disarm_i(disarm),
    .smp_valid_i(valid), .smp_data_i(data), .cfg_we_i(we),
    .cfg_stage_i(stg), .cfg_field_i(fld), .cfg_data_i(wdata),
    .armed_o(armed), .run_o(run), .stage_o(stage)
  );

  // reference model
  logic [31:0] m_mask [NST];
  logic [31:0] m_val  [NST];
  logic [31:0] m_ctl  [NST];
  logic [31:0] m_hist [NST];
  int m_cur = 0;
  bit m_run = 0, m_armed = 0;

  function automatic bit stage_hit(int s, logic [31:0] d);
    logic [31:0] h;
    h = {m_hist[s][30:0], d[m_ctl[s][6:2]]};
    if (m_ctl[s][1]) return ((h ^ m_val[s]) & m_mask[s]) == 0;
    return ((d ^ m_val[s]) & m_mask[s]) == 0;
  endfunction

  task automatic model_step();
    int p = -1;
    bit later = 0;
    if (arm) begin
      m_armed = 1; m_run = 0; m_cur = 0;
      for (int s = 0; s < NST; s++) m_hist[s] = 0;
    end else if (disarm) begin
      m_armed = 0;
    end else if (m_armed && valid) begin
      if (!m_run) begin
        for (int s = NST - 1; s >= m_cur; s--) if (m_ctl[s][0]) p = s;
        for (int s = 0; s < NST; s++) if (p >= 0 && s > p && m_ctl[s][0]) later = 1;
        if (p < 0) m_run = 1;
        else if (stage_hit(p, data)) begin
          if (later) m_cur = p + 1;
          else m_run = 1;
        end
      end
      for (int s = 0; s < NST; s++) m_hist[s] = {m_hist[s][30:0], data[m_ctl[s][6:2]]};
    end
    if (we && !m_armed_prev) begin
      case (fld)
        2'd0: m_mask[stg] = wdata;
        2'd1: m_val[stg]  = wdata;
        2'd2: m_ctl[stg]  = wdata;
        default: ;
      endcase
    end
  endtask
  bit m_armed_prev = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(bit a, bit da, bit v, logic [31:0] d, bit w,
                      logic [1:0] s, logic [1:0] f, logic [31:0] wd);
    @(negedge clk);
    arm = a; disarm = da; valid = v; data = d; we = w; stg = s; fld = f; wdata = wd;
    @(posedge clk);
    #1;
    m_armed_prev = m_armed;
    model_step();
    chk("R4 stage_o vs model", 32'(stage), 32'(m_cur));
    chk("R5 run_o vs model", 32'(run), 32'(m_run));
    chk("R12 armed_o vs model", 32'(armed), 32'(m_armed));
  endtask

  task automatic wr(int s, int f, logic [31:0] d);
    tick(0, 0, 0, 0, 1, 2'(s), 2'(f), d);
  endtask
  task automatic do_arm();    tick(1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_disarm(); tick(0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic smp(logic [31:0] d); tick(0, 0, 1, d, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NST; s++) begin
      m_mask[s] = 0; m_val[s] = 0; m_ctl[s] = 0; m_hist[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 armed after reset", 32'(armed), 0);
    chk("R11 run after reset", 32'(run), 0);
    chk("R11 stage after reset", 32'(stage), 0);

    // R6: nothing enabled
    do_arm();
    smp(32'hdead_beef);
    chk("R6 run with no stage enabled", 32'(run), 1);
    // R8 hold, R12 disarm keeps run, R10 arm clears
    smp(0); smp(32'hffff_ffff); smp(1);
    chk("R8 run held", 32'(run), 1);
    do_disarm();
    chk("R12 disarm keeps run", 32'(run), 1);
    do_arm();
    chk("R10 arm clears run", 32'(run), 0);
    chk("R10 arm clears stage", 32'(stage), 0);
    do_disarm();

    // R1 / R2 parallel
    wr(0, 0, 32'h0000_00f0); wr(0, 1, 32'h0000_00a0); wr(0, 2, 32'h1);
    do_arm();
    smp(32'h0000_005a);
    chk("R1 mismatch on masked bits", 32'(run), 0);
    smp(32'h1234_56af);
    chk("R2 unmasked bits ignored", 32'(run), 1);

    // R7 invalid cycles ignored
    do_arm();
    tick(0, 0, 0, 32'h0000_00a0, 0, 0, 0, 0);
    chk("R7 no eval without valid", 32'(run), 0);
    smp(32'h0000_00a0);
    chk("R7 eval on valid", 32'(run), 1);
    do_disarm();

    // R4 one stage per sample
    wr(0, 0, 32'hf); wr(0, 1, 32'h3);
    wr(1, 0, 32'hf0); wr(1, 1, 32'h50); wr(1, 2, 32'h1);
    do_arm();
    smp(32'h53);
    chk("R4 stage advanced", 32'(stage), 1);
    chk("R4 later stage not judged same sample", 32'(run), 0);
    smp(32'h53);
    chk("R4 second stage matched", 32'(run), 1);
    do_disarm();

    // R5 skip disabled stage
    wr(1, 2, 32'h0);
    wr(2, 0, 32'hf00); wr(2, 1, 32'h700); wr(2, 2, 32'h1);
    do_arm();
    smp(32'h703);
    chk("R5 first stage met, no run", 32'(run), 0);
    smp(32'h700);
    chk("R5 last enabled stage starts run", 32'(run), 1);
    do_disarm();

    // R3 serial on channel 5, pattern 101 newest in bit 0
    wr(2, 2, 32'h0);
    wr(0, 2, 32'h1 | 32'h2 | (32'd5 << 2)); wr(0, 0, 32'h7); wr(0, 1, 32'h5);
    do_arm();
    smp(32'h20);
    smp(32'h0);
    chk("R3 partial history", 32'(run), 0);
    smp(32'h20);
    chk("R3 serial pattern", 32'(run), 1);
    do_disarm();

    // R10 history cleared on arm
    wr(0, 0, 32'h3); wr(0, 1, 32'h0);
    do_arm();
    smp(32'h20); smp(32'h20);
    chk("R10 ones in history", 32'(run), 0);
    do_arm();
    smp(32'h0);
    chk("R10 history cleared", 32'(run), 1);
    do_disarm();

    // R9 writes locked while armed
    wr(0, 2, 32'h1); wr(0, 0, 32'hff); wr(0, 1, 32'h11);
    do_arm();
    wr(0, 1, 32'h22);
    smp(32'h22);
    chk("R9 write while armed ignored", 32'(run), 0);
    smp(32'h11);
    chk("R9 old value still used", 32'(run), 1);

    // random phase
    for (int t = 0; t < 60; t++) begin
      do_disarm();
      for (int s = 0; s < NST; s++) begin
        wr(s, 0, $urandom & $urandom & $urandom & $urandom);
        wr(s, 1, $urandom);
        wr(s, 2, {25'd0, 5'($urandom), 1'($urandom), 1'(($urandom % 4) != 0)});
      end
      do_arm();
      for (int k = 0; k < 80; k++) begin
        int r = $urandom % 40;
        if (r == 0)      do_arm();
        else if (r == 1) wr($urandom % NST, $urandom % 3, $urandom);
        else tick(0, 0, 1'(($urandom % 4) != 0), $urandom, 0, 0, 0, 0);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule